// File: doc/BRIEF.md
# Banked Data Memory Address Decoder

This block sits between the load/store side of a small 8-bit microcontroller core and its data storage. Every CPU read or write carries an 8-bit address. The block decides whether that address belongs to the special-function register window, the shared global register window, or the banked RAM area. It then performs the access or hands it on to the peripheral that owns it. The block keeps three registers of its own: a bank selector and two memory pointers. It holds the RAM for two general-purpose banks, a display/configuration bank and the global registers.

Two addresses in the special-function window are not storage. They are indirect ports, and an access to one is redirected to the address held in its paired pointer. The first port always lands in bank 0. The second follows the bank selector. Addresses with no implementation read as zero and absorb writes. So do partly implemented nibbles and banks that do not exist. Peripheral registers outside this block receive read and write strobes, a 5-bit register index and, for reads, return their data on a side input.

All read data appears on `rdData` one clock after the cycle in which `rdEn` is high. It then holds until the next read.

Top module: `dmem_router`

## Requirements
- R1: After reset, reads of the bank selector (04h) and both memory pointers (01h, 03h) return 00h.
- R2: Writes to 01h, 03h and 04h store the full byte. A read presents its data on `rdData` in the cycle after `rdEn`, and the value holds until the next read.
- R3: Addresses 20h–3Fh reach one 32-byte store whatever the bank selector holds.
- R4: Addresses 40h–FFh reach bank 0 when the selector is 00h and bank 1 when it is 01h. The two banks keep separate contents.
- R5: When the selector holds a value other than 00h, 01h or 1Bh, banked reads return 00h and banked writes change no stored byte.
- R6: An access to 02h is redirected to the address in the pointer at 03h, using the current bank selector. This includes special-function targets such as 04h.
- R7: An access to 00h is redirected to the address in the pointer at 01h and always reaches bank 0, whatever the selector holds.
- R8: An indirect access whose pointer holds 00h or 02h reads 00h. As a write, it raises no strobe and alters no register.
- R9: Reserved special-function addresses 0Ch, 0Fh, 13h and 18h–1Ch read 00h, raise no peripheral strobe and keep nothing written to them.
- R10: With the selector at 1Bh, 40h–4Eh hold full bytes. For C0h–E2h only bits 3:0 are stored and bits 7:4 read as 0. 4Fh–BFh and E3h–FFh read 00h.
- R11: 1Dh is write-only: a write raises `periphWrStb`, and a read returns 00h without `periphRdStb`. 1Fh is read-only: a read raises `periphRdStb`, and a write raises no strobe.
- R12: For the peripheral-owned addresses (05h–0Bh, 0Dh, 0Eh, 10h–12h, 14h–17h, 1Eh), an access raises the matching strobe in the same cycle with `periphAddr` equal to address bits 4:0. `periphRdData` sampled in that cycle is returned, with bits 7:4 forced to 0 for 16h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| addr | input | 8 | CPU data address |
| wrData | input | 8 | CPU write data |
| rdEn | input | 1 | Read request for this cycle |
| wrEn | input | 1 | Write request for this cycle |
| rdData | output | 8 | Read result, valid the cycle after `rdEn` |
| periphRdStb | output | 1 | Read select to the peripheral register at `periphAddr` |
| periphWrStb | output | 1 | Write select to the peripheral register at `periphAddr` |
| periphAddr | output | 5 | Special-function register index of the current access |
| periphRdData | input | 8 | Data from the selected peripheral register, same cycle as `periphRdStb` |

## Verification
The embedded properties assume the CPU never raises `rdEn` and `wrEn` in the same cycle. They also assume the peripheral answers combinationally during the cycle it is strobed. The stimulus respects both: every task drives exactly one request per cycle, and the bench models the peripheral as a pure function of `periphAddr`. Sweeps cover every banked address in each implemented bank, every global register, every special-function index and a spread of pointer targets. Expected bytes come from an arithmetic pattern of bank and address.

// File: rtl/dmem_pkg.sv
package dmem_pkg;

  // Architectural address map (8-bit data space)
  localparam logic [7:0] IND0_ADDR      = 8'h00;
  localparam logic [7:0] PTR0_ADDR      = 8'h01;
  localparam logic [7:0] IND1_ADDR      = 8'h02;
  localparam logic [7:0] PTR1_ADDR      = 8'h03;
  localparam logic [7:0] BANKSEL_ADDR   = 8'h04;
  localparam logic [7:0] GLOBAL_BASE    = 8'h20;
  localparam logic [7:0] BANKED_BASE    = 8'h40;
  localparam logic [7:0] DISP_BYTE_LAST = 8'h4E;
  localparam logic [7:0] DISP_NIB_FIRST = 8'hC0;
  localparam logic [7:0] DISP_NIB_LAST  = 8'hE2;

  // Special-function indices with special handling
  localparam logic [4:0] SFR_WRITE_ONLY = 5'h1D;
  localparam logic [4:0] SFR_READ_ONLY  = 5'h1F;
  localparam logic [4:0] SFR_HALF_WIDE  = 5'h16;
  localparam logic [4:0] SFR_FIRST_PERI = 5'h05;

  localparam int BANK_DEPTH      = 256 - int'(BANKED_BASE);
  localparam int GLOBAL_DEPTH    = int'(BANKED_BASE) - int'(GLOBAL_BASE);
  localparam int DISP_BYTE_DEPTH = int'(DISP_BYTE_LAST) - int'(BANKED_BASE) + 1;
  localparam int DISP_NIB_DEPTH  = int'(DISP_NIB_LAST) - int'(DISP_NIB_FIRST) + 1;
  localparam int GP_SEL_W        = 4;

  typedef enum logic [3:0] {
    SRC_ZERO,
    SRC_MP0,
    SRC_MP1,
    SRC_BANKSEL,
    SRC_PERIPH,
    SRC_GLOBAL,
    SRC_GPBANK,
    SRC_DISPBYTE,
    SRC_DISPNIB
  } rdSrc_e;

  typedef struct packed {
    logic                mp0Wr;
    logic                mp1Wr;
    logic                bankSelWr;
    logic                gblWr;
    logic                gpWr;
    logic                dispByteWr;
    logic                dispNibWr;
    logic                rdFire;
    logic                maskHi;
    rdSrc_e              rdSrc;
    logic [7:0]          bankOff;
    logic [4:0]          gblIdx;
    logic [GP_SEL_W-1:0] gpSel;
  } ctrlStb_t;

  function automatic logic sfrReserved(input logic [4:0] idx);
    return (idx == 5'h0C) || (idx == 5'h0F) || (idx == 5'h13) ||
           ((idx >= 5'h18) && (idx <= 5'h1C));
  endfunction

  function automatic logic periphReadable(input logic [4:0] idx);
    return (idx >= SFR_FIRST_PERI) && !sfrReserved(idx) && (idx != SFR_WRITE_ONLY);
  endfunction

  function automatic logic periphWritable(input logic [4:0] idx);
    return (idx >= SFR_FIRST_PERI) && !sfrReserved(idx) && (idx != SFR_READ_ONLY);
  endfunction

endpackage

// File: rtl/dmem_sram.sv
module dmem_sram #(
  parameter int DEPTH = 32,
  parameter int WIDTH = 8,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             we,
  input  logic             re,
  input  logic [AW-1:0]    addr,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] rdata
);

  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    if (re) rdata <= mem[addr];
  end

endmodule

// File: rtl/dmem_ctrl.sv
module dmem_ctrl
  import dmem_pkg::*;
#(
  parameter int         GP_BANKS     = 2,
  parameter logic [7:0] DISP_BANK_ID = 8'h1B
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [7:0] addr,
  input  logic       rdEn,
  input  logic       wrEn,
  input  logic [7:0] mp0,
  input  logic [7:0] mp1,
  input  logic [7:0] bankSel,
  output ctrlStb_t   stb,
  output logic       periphRdStb,
  output logic       periphWrStb,
  output logic [4:0] periphAddr
);

  localparam logic [7:0] GP_LIMIT = 8'(GP_BANKS);

  logic [7:0] effAddr;
  logic [7:0] effBank;
  logic       viaPort0;
  logic       viaPort1;
  logic       selfRef;

  // Resolve indirect ports into an effective address and bank
  always_comb begin
    viaPort0 = (addr == IND0_ADDR);
    viaPort1 = (addr == IND1_ADDR);
    effAddr  = addr;
    effBank  = bankSel;
    if (viaPort0) begin
      effAddr = mp0;
      effBank = 8'h00;
    end else if (viaPort1) begin
      effAddr = mp1;
    end
    selfRef = (viaPort0 || viaPort1) &&
              ((effAddr == IND0_ADDR) || (effAddr == IND1_ADDR));
  end

  // Region decode
  always_comb begin
    stb         = '0;
    stb.rdSrc   = SRC_ZERO;
    stb.rdFire  = rdEn;
    periphRdStb = 1'b0;
    periphWrStb = 1'b0;
    periphAddr  = effAddr[4:0];
    if (!selfRef) begin
      if (effAddr < GLOBAL_BASE) begin
        if (effAddr == PTR0_ADDR) begin
          stb.rdSrc = SRC_MP0;
          stb.mp0Wr = wrEn;
        end else if (effAddr == PTR1_ADDR) begin
          stb.rdSrc = SRC_MP1;
          stb.mp1Wr = wrEn;
        end else if (effAddr == BANKSEL_ADDR) begin
          stb.rdSrc     = SRC_BANKSEL;
          stb.bankSelWr = wrEn;
        end else begin
          if (periphReadable(effAddr[4:0])) begin
            stb.rdSrc   = SRC_PERIPH;
            periphRdStb = rdEn;
          end
          periphWrStb = wrEn && periphWritable(effAddr[4:0]);
          stb.maskHi  = (effAddr[4:0] == SFR_HALF_WIDE);
        end
      end else if (effAddr < BANKED_BASE) begin
        stb.rdSrc  = SRC_GLOBAL;
        stb.gblWr  = wrEn;
        stb.gblIdx = effAddr[4:0];
      end else if (effBank < GP_LIMIT) begin
        stb.rdSrc   = SRC_GPBANK;
        stb.gpWr    = wrEn;
        stb.gpSel   = effBank[GP_SEL_W-1:0];
        stb.bankOff = effAddr - BANKED_BASE;
      end else if (effBank == DISP_BANK_ID) begin
        if (effAddr <= DISP_BYTE_LAST) begin
          stb.rdSrc      = SRC_DISPBYTE;
          stb.dispByteWr = wrEn;
          stb.bankOff    = effAddr - BANKED_BASE;
        end else if ((effAddr >= DISP_NIB_FIRST) && (effAddr <= DISP_NIB_LAST)) begin
          stb.rdSrc     = SRC_DISPNIB;
          stb.dispNibWr = wrEn;
          stb.bankOff   = effAddr - DISP_NIB_FIRST;
        end
      end
    end
  end

  // Input contract: one request per cycle (R2)
  p_single_request_r2: assert property (@(posedge clk) disable iff (!rstN)
    !(rdEn && wrEn));

  // Write-only register never sees a read strobe, read-only never a write (R11)
  p_wo_no_read_r11: assert property (@(posedge clk) disable iff (!rstN)
    periphRdStb |-> (periphAddr != SFR_WRITE_ONLY));
  p_ro_no_write_r11: assert property (@(posedge clk) disable iff (!rstN)
    periphWrStb |-> (periphAddr != SFR_READ_ONLY));

  // Direct access to a reserved index never reaches a peripheral (R9)
  p_reserved_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    ((addr < GLOBAL_BASE) && sfrReserved(addr[4:0])) |-> !(periphRdStb || periphWrStb));

  // Pointer aimed at a port: no write of any kind (R8)
  p_self_ref_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    (((addr == IND0_ADDR) && ((mp0 == IND0_ADDR) || (mp0 == IND1_ADDR))) ||
     ((addr == IND1_ADDR) && ((mp1 == IND0_ADDR) || (mp1 == IND1_ADDR))))
    |-> !(periphWrStb || stb.gpWr || stb.gblWr || stb.mp0Wr || stb.mp1Wr || stb.bankSelWr));

  // Banked writes only into existing banks (R5)
  p_gp_bank_exists_r5: assert property (@(posedge clk) disable iff (!rstN)
    stb.gpWr |-> (8'(stb.gpSel) < GP_LIMIT));

endmodule

// File: rtl/dmem_dp.sv
module dmem_dp
  import dmem_pkg::*;
#(
  parameter int GP_BANKS = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  ctrlStb_t   stb,
  input  logic [7:0] wrData,
  input  logic [7:0] periphRdData,
  output logic [7:0] rdData,
  output logic [7:0] mp0,
  output logic [7:0] mp1,
  output logic [7:0] bankSel
);

  localparam int BANK_AW = $clog2(BANK_DEPTH);
  localparam int GBL_AW  = $clog2(GLOBAL_DEPTH);
  localparam int DB_AW   = $clog2(DISP_BYTE_DEPTH);
  localparam int DN_AW   = $clog2(DISP_NIB_DEPTH);

  // Pointer and bank selector registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mp0     <= 8'h00;
      mp1     <= 8'h00;
      bankSel <= 8'h00;
    end else begin
      if (stb.mp0Wr)     mp0     <= wrData;
      if (stb.mp1Wr)     mp1     <= wrData;
      if (stb.bankSelWr) bankSel <= wrData;
    end
  end

  // General-purpose banks
  logic [7:0] gpQ [GP_BANKS];
  for (genvar i = 0; i < GP_BANKS; i++) begin : g_gp_bank
    dmem_sram #(.DEPTH(BANK_DEPTH), .WIDTH(8)) u_bank (
      .clk  (clk),
      .we   (stb.gpWr && (stb.gpSel == GP_SEL_W'(i))),
      .re   (stb.rdFire && (stb.rdSrc == SRC_GPBANK) && (stb.gpSel == GP_SEL_W'(i))),
      .addr (stb.bankOff[BANK_AW-1:0]),
      .wdata(wrData),
      .rdata(gpQ[i])
    );
  end

  logic [7:0] gblQ;
  dmem_sram #(.DEPTH(GLOBAL_DEPTH), .WIDTH(8)) u_global (
    .clk  (clk),
    .we   (stb.gblWr),
    .re   (stb.rdFire && (stb.rdSrc == SRC_GLOBAL)),
    .addr (stb.gblIdx[GBL_AW-1:0]),
    .wdata(wrData),
    .rdata(gblQ)
  );

  logic [7:0] dbQ;
  dmem_sram #(.DEPTH(DISP_BYTE_DEPTH), .WIDTH(8)) u_disp_byte (
    .clk  (clk),
    .we   (stb.dispByteWr),
    .re   (stb.rdFire && (stb.rdSrc == SRC_DISPBYTE)),
    .addr (stb.bankOff[DB_AW-1:0]),
    .wdata(wrData),
    .rdata(dbQ)
  );

  logic [3:0] dnQ;
  dmem_sram #(.DEPTH(DISP_NIB_DEPTH), .WIDTH(4)) u_disp_nib (
    .clk  (clk),
    .we   (stb.dispNibWr),
    .re   (stb.rdFire && (stb.rdSrc == SRC_DISPNIB)),
    .addr (stb.bankOff[DN_AW-1:0]),
    .wdata(wrData[3:0]),
    .rdata(dnQ)
  );

  // Register-type read sources are captured at the read cycle
  logic [7:0]          capNext;
  logic [7:0]          capQ;
  rdSrc_e              srcQ;
  logic [GP_SEL_W-1:0] gpSelQ;

  always_comb begin
    unique case (stb.rdSrc)
      SRC_MP0:     capNext = mp0;
      SRC_MP1:     capNext = mp1;
      SRC_BANKSEL: capNext = bankSel;
      SRC_PERIPH:  capNext = stb.maskHi ? {4'h0, periphRdData[3:0]} : periphRdData;
      default:     capNext = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capQ   <= 8'h00;
      srcQ   <= SRC_ZERO;
      gpSelQ <= '0;
    end else if (stb.rdFire) begin
      capQ   <= capNext;
      srcQ   <= stb.rdSrc;
      gpSelQ <= stb.gpSel;
    end
  end

  logic [7:0] gpPick;
  always_comb begin
    gpPick = 8'h00;
    for (int i = 0; i < GP_BANKS; i++) begin
      if (gpSelQ == GP_SEL_W'(i)) gpPick = gpQ[i];
    end
  end

  always_comb begin
    unique case (srcQ)
      SRC_GLOBAL:   rdData = gblQ;
      SRC_GPBANK:   rdData = gpPick;
      SRC_DISPBYTE: rdData = dbQ;
      SRC_DISPNIB:  rdData = {4'h0, dnQ};
      default:      rdData = capQ;
    endcase
  end

  // Unmapped reads return zero next cycle (R9)
  p_zero_read_r9: assert property (@(posedge clk) disable iff (!rstN)
    (stb.rdFire && (stb.rdSrc == SRC_ZERO)) |=> (rdData == 8'h00));

  // Display nibble region: upper nibble zero (R10)
  p_nib_upper_zero_r10: assert property (@(posedge clk) disable iff (!rstN)
    (stb.rdFire && (stb.rdSrc == SRC_DISPNIB)) |=> (rdData[7:4] == 4'h0));

  // Half-wide peripheral register masked (R12)
  p_half_wide_mask_r12: assert property (@(posedge clk) disable iff (!rstN)
    (stb.rdFire && (stb.rdSrc == SRC_PERIPH) && stb.maskHi) |=> (rdData[7:4] == 4'h0));

  // Read result holds between reads (R2)
  p_rd_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !stb.rdFire |=> $stable(rdData));

  // Bank selector changes only on its own write (R5)
  p_banksel_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    !stb.bankSelWr |=> $stable(bankSel));

endmodule

// File: rtl/dmem_router.sv
module dmem_router
  import dmem_pkg::*;
#(
  parameter int         GP_BANKS     = 2,
  parameter logic [7:0] DISP_BANK_ID = 8'h1B
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [7:0] addr,
  input  logic [7:0] wrData,
  input  logic       rdEn,
  input  logic       wrEn,
  output logic [7:0] rdData,
  output logic       periphRdStb,
  output logic       periphWrStb,
  output logic [4:0] periphAddr,
  input  logic [7:0] periphRdData
);

  ctrlStb_t   stb;
  logic [7:0] mp0;
  logic [7:0] mp1;
  logic [7:0] bankSel;

  dmem_ctrl #(.GP_BANKS(GP_BANKS), .DISP_BANK_ID(DISP_BANK_ID)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .addr       (addr),
    .rdEn       (rdEn),
    .wrEn       (wrEn),
    .mp0        (mp0),
    .mp1        (mp1),
    .bankSel    (bankSel),
    .stb        (stb),
    .periphRdStb(periphRdStb),
    .periphWrStb(periphWrStb),
    .periphAddr (periphAddr)
  );

  dmem_dp #(.GP_BANKS(GP_BANKS)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .wrData      (wrData),
    .periphRdData(periphRdData),
    .rdData      (rdData),
    .mp0         (mp0),
    .mp1         (mp1),
    .bankSel     (bankSel)
  );

endmodule

// File: tb/dmem_router_tb.sv
module dmem_router_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] addr = 8'h00;
  logic [7:0] wrData = 8'h00;
  logic       rdEn = 1'b0;
  logic       wrEn = 1'b0;
  logic [7:0] rdData;
  logic       periphRdStb;
  logic       periphWrStb;
  logic [4:0] periphAddr;
  logic [7:0] periphRdData;

  int nTotal = 0;
  int nFail  = 0;
  logic       lastRdStb, lastWrStb;
  logic [4:0] lastPAddr;
  logic [7:0] d;

  always #2.5 clk = ~clk;

  // Peripheral model: pure function of the index
  assign periphRdData = {periphAddr, 3'b011};

  dmem_router u_dut (
    .clk(clk), .rstN(rstN), .addr(addr), .wrData(wrData), .rdEn(rdEn), .wrEn(wrEn),
    .rdData(rdData), .periphRdStb(periphRdStb), .periphWrStb(periphWrStb),
    .periphAddr(periphAddr), .periphRdData(periphRdData)
  );

  function automatic logic [7:0] pat(input logic [7:0] b, input logic [7:0] a);
    return 8'(a * 8'd3) ^ b ^ 8'h5A;
  endfunction

  function automatic logic [7:0] dispExp(input logic [7:0] a);
    if (a <= 8'h4E) return pat(8'h1B, a);
    if (a >= 8'hC0 && a <= 8'hE2) return pat(8'h1B, a) & 8'h0F;
    return 8'h00;
  endfunction

  function automatic logic isRsv(input logic [7:0] a);
    return (a == 8'h0C) || (a == 8'h0F) || (a == 8'h13) || (a >= 8'h18 && a <= 8'h1C);
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    nTotal++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] v);
    @(negedge clk);
    addr = a; wrData = v; wrEn = 1'b1;
    #1;
    lastWrStb = periphWrStb; lastRdStb = periphRdStb; lastPAddr = periphAddr;
    @(posedge clk);
    #1 wrEn = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] v);
    @(negedge clk);
    addr = a; rdEn = 1'b1;
    #1;
    lastWrStb = periphWrStb; lastRdStb = periphRdStb; lastPAddr = periphAddr;
    @(posedge clk);
    #1 rdEn = 1'b0;
    @(negedge clk);
    v = rdData;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nTotal++; nFail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nTotal - nFail, nTotal);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state
    check("R1 rdData after reset", rdData, 8'h00);
    rd(8'h04, d); check("R1 bank selector", d, 8'h00);
    rd(8'h01, d); check("R1 mp0", d, 8'h00);
    rd(8'h03, d); check("R1 mp1", d, 8'h00);

    // R2: pointer and selector storage, latency, hold
    foreach (d[i]) begin
      logic [7:0] v;
      v = 8'(8'h91 * (i + 1));
      wr(8'h01, v); rd(8'h01, d); check("R2 mp0 write/read", d, v);
      wr(8'h03, ~v); rd(8'h03, d); check("R2 mp1 write/read", d, ~v);
    end
    wr(8'h04, 8'h1B); rd(8'h04, d); check("R2 bank selector", d, 8'h1B);
    repeat (3) @(negedge clk);
    check("R2 read data holds", rdData, 8'h1B);

    // R3: global window shared by all banks
    wr(8'h04, 8'h00);
    for (int i = 0; i < 32; i++) wr(8'(8'h20 + i), 8'(i * 7 + 3));
    wr(8'h04, 8'h1B);
    for (int i = 0; i < 32; i++) begin
      rd(8'(8'h20 + i), d); check("R3 global under bank 1B", d, 8'(i * 7 + 3));
    end
    wr(8'h04, 8'h01);
    rd(8'h3F, d); check("R3 global under bank 01", d, 8'(31 * 7 + 3));

    // R4 / R10: fill and read back every banked address of each bank
    for (int b = 0; b < 3; b++) begin
      logic [7:0] bid;
      bid = (b == 2) ? 8'h1B : 8'(b);
      wr(8'h04, bid);
      for (int a = 8'h40; a <= 8'hFF; a++) wr(8'(a), pat(bid, 8'(a)));
    end
    for (int b = 0; b < 3; b++) begin
      logic [7:0] bid;
      bid = (b == 2) ? 8'h1B : 8'(b);
      wr(8'h04, bid);
      for (int a = 8'h40; a <= 8'hFF; a++) begin
        rd(8'(a), d);
        if (b == 2) check("R10 display bank map", d, dispExp(8'(a)));
        else        check("R4 general bank", d, pat(bid, 8'(a)));
      end
    end

    // R5: nonexistent bank reads zero and ignores writes
    wr(8'h04, 8'h07);
    for (int a = 8'h40; a <= 8'hFF; a += 5) begin
      wr(8'(a), 8'hFF);
      rd(8'(a), d); check("R5 absent bank reads zero", d, 8'h00);
    end
    wr(8'h04, 8'h00);
    for (int a = 8'h40; a <= 8'hFF; a += 5) begin
      rd(8'(a), d); check("R5 bank0 untouched", d, pat(8'h00, 8'(a)));
    end
    wr(8'h04, 8'h1B);
    rd(8'h45, d); check("R5 display bank untouched", d, pat(8'h1B, 8'h45));

    // R6: port at 02h follows the selector
    wr(8'h04, 8'h01);
    for (int a = 8'h40; a <= 8'hFF; a += 9) begin
      wr(8'h03, 8'(a)); wr(8'h02, ~pat(8'h01, 8'(a)));
      rd(8'h02, d); check("R6 indirect port1 read", d, ~pat(8'h01, 8'(a)));
      rd(8'(a), d); check("R6 lands in bank1", d, ~pat(8'h01, 8'(a)));
    end
    wr(8'h03, 8'h20); rd(8'h02, d); check("R6 indirect global", d, 8'h03);
    wr(8'h03, 8'h04); wr(8'h02, 8'h00);
    rd(8'h04, d); check("R6 indirect write of selector", d, 8'h00);

    // R7: port at 00h always bank 0
    wr(8'h04, 8'h01);
    for (int a = 8'h40; a <= 8'hFF; a += 11) begin
      wr(8'h01, 8'(a)); wr(8'h00, 8'(a) ^ 8'hC3);
      rd(8'h00, d); check("R7 indirect port0 read", d, 8'(a) ^ 8'hC3);
    end
    rd(8'h04, d); check("R7 selector unchanged", d, 8'h01);
    wr(8'h04, 8'h00);
    for (int a = 8'h40; a <= 8'hFF; a += 11) begin
      rd(8'(a), d); check("R7 lands in bank0", d, 8'(a) ^ 8'hC3);
    end

    // R8: pointer aimed at a port
    wr(8'h01, 8'h00); rd(8'h00, d); check("R8 port0 via 00", d, 8'h00);
    wr(8'h01, 8'h02); rd(8'h00, d); check("R8 port0 via 02", d, 8'h00);
    wr(8'h00, 8'h55);
    check("R8 no write strobe", 8'(lastWrStb), 8'h00);
    wr(8'h03, 8'h00); rd(8'h02, d); check("R8 port1 via 00", d, 8'h00);
    wr(8'h03, 8'h02); rd(8'h02, d); check("R8 port1 via 02", d, 8'h00);
    wr(8'h02, 8'h77);
    check("R8 no write strobe port1", 8'(lastWrStb), 8'h00);
    rd(8'h01, d); check("R8 mp0 unchanged", d, 8'h02);
    rd(8'h03, d); check("R8 mp1 unchanged", d, 8'h02);
    rd(8'h04, d); check("R8 selector unchanged", d, 8'h00);

    // R9: reserved special-function addresses
    for (int a = 0; a < 32; a++) begin
      if (isRsv(8'(a))) begin
        wr(8'(a), 8'hFF);
        check("R9 reserved no write strobe", 8'(lastWrStb), 8'h00);
        rd(8'(a), d);
        check("R9 reserved reads zero", d, 8'h00);
        check("R9 reserved no read strobe", 8'(lastRdStb), 8'h00);
      end
    end

    // R11 / R12: peripheral-owned addresses
    for (int a = 5; a < 32; a++) begin
      if (!isRsv(8'(a))) begin
        logic [7:0] ex;
        wr(8'(a), 8'hA5);
        check("R11 write strobe", 8'(lastWrStb), (a == 8'h1F) ? 8'h00 : 8'h01);
        if (a != 8'h1F) check("R12 write index", 8'(lastPAddr), 8'(a));
        rd(8'(a), d);
        check("R11 read strobe", 8'(lastRdStb), (a == 8'h1D) ? 8'h00 : 8'h01);
        ex = {5'(a), 3'b011};
        if (a == 8'h1D) ex = 8'h00;
        if (a == 8'h16) ex = ex & 8'h0F;
        check("R12 peripheral read data", d, ex);
      end
    end
    wr(8'h03, 8'h16); rd(8'h02, d);
    check("R12 indirect half-wide mask", d, 8'h03);

    $display("%0d/%0d checks passed", nTotal - nFail, nTotal);
    $finish;
  end

endmodule